// File: doc/BRIEF.md
# Touch Digitizer Serial Slave Sequencer

This block is the digital core on the device side of a four-wire resistive touch digitizer. A host selects it with an active-low chip select, supplies a serial clock and shifts in a command byte. The command byte opens with a high start bit and carries a channel code, a resolution choice, a reference-mode choice and a power-policy code. The block uses these fields to set up the input multiplexer and the panel drivers for an acquisition window. At the end of that window it samples a conversion word, raises BUSY for one serial clock, and then returns the word most significant bit first on its data output.

The analog converter is not part of the block. Its result is a parallel input word that is captured at the end of acquisition. The serial clock, chip select and data input are sampled in the system clock domain, which must run several times faster than the serial clock. The host can start the next command while the tail of the previous result is still being shifted out. This allows back-to-back conversions in 15 serial clocks at full resolution and 11 at short resolution.

Top module: `touch_seq_core`

## Requirements
- R1: The data input is sampled only on rising serial clock edges and is ignored until it reads high. That high bit is the start bit, and the next seven bits complete the command: channel bits C2..C0, then the resolution bit (0 = 12-bit, 1 = 8-bit), then the reference bit (1 = single-ended, 0 = ratiometric), then the power bits P1, P0.
- R2: BUSY rises on the falling serial edge that follows the eighth rising edge of a command (counting the start bit as the first). It falls on the next falling edge.
- R3: The conversion word is sampled on the falling edge at which BUSY rises. From the following falling edge onward, each falling edge puts one result bit on the data output, MSB first: all 12 bits in 12-bit mode, or bits 11 to 4 of the word in 8-bit mode. The data output reads 0 while BUSY is high and after the last bit.
- R4: While chip select is high, both output enables are low, BUSY and the data output are 0, and any partly received command is discarded. A later command needs a fresh start bit.
- R5: After a start bit, the next start bit is accepted no earlier than the 16th rising edge (12-bit) or the 12th rising edge (8-bit), counting the first start bit as edge 1. A high data input before that edge is ignored. An overlapping command does not disturb the bits still being shifted out.
- R6: The channel code and the reference mode are updated on the sixth rising edge. From that edge until BUSY falls, code 101 enables the X drivers and code 001 enables the Y drivers. Every other code enables neither, and both are off at all other times. `ref_ratio` is 1 when the reference bit is 0.
- R7: The power code is taken on the eighth rising edge and kept across chip select. Code 11 holds power on and disables the pen interrupt. Any other code keeps the pen interrupt enabled and asserts power only from the start bit until BUSY falls.
- R8: After reset the outputs are: BUSY 0, data output 0, drivers off, channel code 000, `ref_ratio` 0, power enable 0, pen interrupt enable 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial command data |
| conv_data | input | 12 | Converter result word, sampled at end of acquisition |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for dout |
| busy | output | 1 | Conversion in progress flag |
| busy_oe | output | 1 | Output enable for busy |
| mux_code | output | 3 | Selected input channel code |
| ref_ratio | output | 1 | 1 = ratiometric reference |
| drv_x_en | output | 1 | X panel driver enable |
| drv_y_en | output | 1 | Y panel driver enable |
| pwr_en | output | 1 | Converter power enable |
| pen_irq_en | output | 1 | Pen interrupt enable |

## Verification
The assertions check on every cycle that BUSY rises and the data output changes only right after a falling serial edge. They also check that a high chip select silences BUSY, data and drivers, that an enabled driver matches its channel code, and that power is on whenever BUSY is high or the pen interrupt is off. Only the directed scenarios can show which bit value appears on which edge. The same holds for the 8-bit truncation, the exact edge on which an overlapping start bit is first accepted, and the power code persisting across a chip-select pulse.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

    localparam int CMD_W    = 8;
    localparam int ACQ_CLKS = 3;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_CMD,
        ST_SAMPLE,
        ST_BUSY,
        ST_DRAIN
    } seq_state_e;

    localparam logic [2:0] CH_YPOS = 3'b001;
    localparam logic [2:0] CH_XPOS = 3'b101;
    localparam logic [2:0] CH_AUX3 = 3'b010;
    localparam logic [2:0] CH_AUX4 = 3'b110;

    localparam logic [1:0] PD_AUTO   = 2'b00;
    localparam logic [1:0] PD_ALWAYS = 2'b11;

    typedef struct packed {
        logic [2:0] chan;
        logic       short_res;
        logic       single_ref;
        logic [1:0] pd;
    } cmd_cfg_t;

    typedef struct packed {
        logic x_on;
        logic y_on;
    } drv_t;

    // Panel driver pattern for a channel code (R6)
    function automatic drv_t decode_drivers(input logic [2:0] chan);
        drv_t d;
        d = '{x_on: 1'b0, y_on: 1'b0};
        case (chan)
            CH_XPOS: d.x_on = 1'b1;
            CH_YPOS: d.y_on = 1'b1;
            default: d = '{x_on: 1'b0, y_on: 1'b0};
        endcase
        return d;
    endfunction

    // Reserved codes behave like PD_AUTO (R7)
    function automatic logic stays_powered(input logic [1:0] pd);
        return pd == PD_ALWAYS;
    endfunction

    // Rising-edge index (start bit = 1) at which a new start may be taken (R5)
    function automatic int first_restart(input int res_bits);
        return res_bits + CMD_W - ACQ_CLKS - 1;
    endfunction

endpackage

// File: rtl/tsq_edge.sv
module tsq_edge (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk;
    end

    assign rise = sclk & ~sclk_q;
    assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/tsq_ctrl.sv
module tsq_ctrl
    import tsq_pkg::*;
#(
    parameter int RES_W = 12,
    parameter int LOW_W = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_n,
    input  logic     rise,
    input  logic     fall,
    input  logic     din,
    output cmd_cfg_t cfg,
    output logic     load,
    output logic     busy,
    output logic     active,
    output logic     in_xfer
);
    localparam int CNT_W    = $clog2(RES_W + CMD_W + 1);
    localparam int WIN_FULL = first_restart(RES_W);
    localparam int WIN_LOW  = first_restart(LOW_W);
    localparam logic [CNT_W-1:0] REF_AT   = CNT_W'(CMD_W - ACQ_CLKS);
    localparam logic [CNT_W-1:0] LAST_AT  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] WIN_F_C  = CNT_W'(WIN_FULL);
    localparam logic [CNT_W-1:0] WIN_L_C  = CNT_W'(WIN_LOW);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nxt;
    logic [CNT_W-1:0] win;
    logic [5:0]       sr;

    assign nxt     = cnt + 1'b1;
    assign win     = cfg.short_res ? WIN_L_C : WIN_F_C;
    assign load    = (state == ST_SAMPLE) && fall && !cs_n;
    assign in_xfer = (state == ST_CMD) || (state == ST_SAMPLE) || (state == ST_BUSY);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_HUNT;
            cnt    <= '0;
            sr     <= '0;
            cfg    <= '{chan: 3'b000, short_res: 1'b0, single_ref: 1'b1, pd: PD_AUTO};
            busy   <= 1'b0;
            active <= 1'b0;
        end else if (cs_n) begin
            // R4: port reset, power policy kept
            state  <= ST_HUNT;
            cnt    <= '0;
            sr     <= '0;
            busy   <= 1'b0;
            active <= 1'b0;
        end else begin
            unique case (state)
                ST_HUNT: begin
                    if (rise && din) begin
                        state <= ST_CMD;
                        cnt   <= CNT_W'(1);
                    end
                end
                ST_CMD: begin
                    if (rise) begin
                        sr  <= {sr[4:0], din};
                        cnt <= nxt;
                        if (cnt == REF_AT) begin
                            cfg.chan       <= sr[3:1];
                            cfg.single_ref <= din;
                            active         <= 1'b1;
                        end
                        if (cnt == LAST_AT) begin
                            cfg.short_res <= sr[2];
                            cfg.pd        <= {sr[0], din};
                            state         <= ST_SAMPLE;
                        end
                    end
                end
                ST_SAMPLE: begin
                    if (fall) begin
                        busy  <= 1'b1;
                        state <= ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (rise) cnt <= nxt;
                    if (fall) begin
                        busy   <= 1'b0;
                        active <= 1'b0;
                        state  <= ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (rise) begin
                        if (nxt >= win) begin
                            if (din) begin
                                state <= ST_CMD;
                                cnt   <= CNT_W'(1);
                            end else begin
                                state <= ST_HUNT;
                            end
                        end else begin
                            cnt <= nxt;
                        end
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/tsq_shift.sv
module tsq_shift #(
    parameter int RES_W = 12,
    parameter int LOW_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             fall,
    input  logic             load,
    input  logic             short_res,
    input  logic [RES_W-1:0] conv_data,
    output logic             dout
);
    localparam int DROP = RES_W - LOW_W;
    localparam logic [RES_W-1:0] KEEP_MASK = ~RES_W'((64'd1 << DROP) - 64'd1);

    logic [RES_W-1:0] shreg;
    logic [RES_W-1:0] eff;

    assign eff = short_res ? (conv_data & KEEP_MASK) : conv_data;

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            shreg <= '0;
            dout  <= 1'b0;
        end else if (fall) begin
            if (load) begin
                shreg <= eff;
                dout  <= 1'b0;
            end else begin
                dout  <= shreg[RES_W-1];
                shreg <= {shreg[RES_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/tsq_drive.sv
module tsq_drive
    import tsq_pkg::*;
(
    input  logic [2:0] chan,
    input  logic       single_ref,
    input  logic [1:0] pd,
    input  logic       active,
    input  logic       in_xfer,
    output logic [2:0] mux_code,
    output logic       ref_ratio,
    output logic       drv_x_en,
    output logic       drv_y_en,
    output logic       pwr_en,
    output logic       pen_irq_en
);
    drv_t pat;

    always_comb begin
        pat        = decode_drivers(chan);
        mux_code   = chan;
        ref_ratio  = ~single_ref;
        drv_x_en   = active & pat.x_on;
        drv_y_en   = active & pat.y_on;
        pwr_en     = stays_powered(pd) | in_xfer;
        pen_irq_en = ~stays_powered(pd);
    end
endmodule

// File: rtl/touch_seq_core.sv
module touch_seq_core
    import tsq_pkg::*;
#(
    parameter int RES_W = 12,
    parameter int LOW_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    input  logic [RES_W-1:0] conv_data,
    output logic             dout,
    output logic             dout_oe,
    output logic             busy,
    output logic             busy_oe,
    output logic [2:0]       mux_code,
    output logic             ref_ratio,
    output logic             drv_x_en,
    output logic             drv_y_en,
    output logic             pwr_en,
    output logic             pen_irq_en
);
    logic     rise, fall, load, active, in_xfer;
    cmd_cfg_t cfg;

    tsq_edge i_edge (
        .clk (clk),
        .rst (rst),
        .sclk(sclk),
        .rise(rise),
        .fall(fall)
    );

    tsq_ctrl #(.RES_W(RES_W), .LOW_W(LOW_W)) i_ctrl (
        .clk    (clk),
        .rst    (rst),
        .cs_n   (cs_n),
        .rise   (rise),
        .fall   (fall),
        .din    (din),
        .cfg    (cfg),
        .load   (load),
        .busy   (busy),
        .active (active),
        .in_xfer(in_xfer)
    );

    tsq_shift #(.RES_W(RES_W), .LOW_W(LOW_W)) i_shift (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .fall     (fall),
        .load     (load),
        .short_res(cfg.short_res),
        .conv_data(conv_data),
        .dout     (dout)
    );

    tsq_drive i_drive (
        .chan      (cfg.chan),
        .single_ref(cfg.single_ref),
        .pd        (cfg.pd),
        .active    (active),
        .in_xfer   (in_xfer),
        .mux_code  (mux_code),
        .ref_ratio (ref_ratio),
        .drv_x_en  (drv_x_en),
        .drv_y_en  (drv_y_en),
        .pwr_en    (pwr_en),
        .pen_irq_en(pen_irq_en)
    );

    // R4: pins float while deselected
    assign dout_oe = ~cs_n;
    assign busy_oe = ~cs_n;
endmodule

// File: rtl/touch_seq_core_chk.sv
module touch_seq_core_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       sclk,
    input logic       busy,
    input logic       dout,
    input logic [2:0] mux_code,
    input logic       drv_x_en,
    input logic       drv_y_en,
    input logic       pwr_en,
    input logic       pen_irq_en
);
    p_busy_rise_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(sclk) == 1'b0 && $past(sclk, 2) == 1'b1));

    p_busy_drop_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(cs_n)) |-> ($past(sclk) == 1'b0 && $past(sclk, 2) == 1'b1));

    p_dout_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        (!$stable(dout) && !$past(cs_n)) |-> ($past(sclk) == 1'b0 && $past(sclk, 2) == 1'b1));

    p_deselect_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (!busy && !dout && !drv_x_en && !drv_y_en));

    p_x_drive_code_r6: assert property (@(posedge clk) disable iff (rst)
        drv_x_en |-> (mux_code == 3'b101));

    p_y_drive_code_r6: assert property (@(posedge clk) disable iff (rst)
        drv_y_en |-> (mux_code == 3'b001));

    p_pen_off_power_on_r7: assert property (@(posedge clk) disable iff (rst)
        !pen_irq_en |-> pwr_en);

    p_busy_powered_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> pwr_en);
endmodule

bind touch_seq_core touch_seq_core_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .busy      (busy),
    .dout      (dout),
    .mux_code  (mux_code),
    .drv_x_en  (drv_x_en),
    .drv_y_en  (drv_y_en),
    .pwr_en    (pwr_en),
    .pen_irq_en(pen_irq_en)
);

// File: tb/test_touch_seq_core.sv
module test_touch_seq_core;
    localparam int H = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic [11:0] conv_data = 12'h000;
    logic        dout, dout_oe, busy, busy_oe, ref_ratio;
    logic        drv_x_en, drv_y_en, pwr_en, pen_irq_en;
    logic [2:0]  mux_code;

    int   n_chk = 0;
    int   n_bad = 0;
    int   tk = 0;
    bit   done = 1'b0;
    logic cap_dout [0:63];
    logic cap_busy [0:63];

    always #2 clk = ~clk;

    touch_seq_core i_touch_seq_core (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
        .conv_data(conv_data), .dout(dout), .dout_oe(dout_oe),
        .busy(busy), .busy_oe(busy_oe), .mux_code(mux_code),
        .ref_ratio(ref_ratio), .drv_x_en(drv_x_en), .drv_y_en(drv_y_en),
        .pwr_en(pwr_en), .pen_irq_en(pen_irq_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic d);
        din = d;
        repeat (H) @(negedge clk);
        sclk = 1'b1;
        repeat (H) @(negedge clk);
        sclk = 1'b0;
        repeat (H) @(negedge clk);
        if (tk < 63) tk++;
        cap_dout[tk] = dout;
        cap_busy[tk] = busy;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) tick(b[i]);
    endtask

    task automatic zeros(input int n);
        for (int i = 0; i < n; i++) tick(1'b0);
    endtask

    task automatic select();
        cs_n = 1'b0;
        tk = 0;
        repeat (H) @(negedge clk);
    endtask

    task automatic deselect();
        cs_n = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    // Start bit carried by tick s: BUSY on tick s+7, result from tick s+8
    task automatic check_result(input string req, input int s, input logic [11:0] res, input bit short_mode);
        int n;
        n = short_mode ? 8 : 12;
        check({req, " busy before"}, cap_busy[s+6], 1'b0);
        check({req, " busy"}, cap_busy[s+7], 1'b1);
        check({req, " dout while busy"}, cap_dout[s+7], 1'b0);
        check({req, " busy after"}, cap_busy[s+8], 1'b0);
        for (int i = 0; i < n; i++)
            check($sformatf("%s bit %0d", req, 11 - i), cap_dout[s+8+i], res[11-i]);
        if (s + 8 + n <= tk) check({req, " trailing dout"}, cap_dout[s+8+n], 1'b0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 busy", busy, 1'b0);
        check("R8 dout", dout, 1'b0);
        check("R8 drivers", {drv_x_en, drv_y_en}, 2'b00);
        check("R8 mux", mux_code, 3'b000);
        check("R8 ref_ratio", ref_ratio, 1'b0);
        check("R8 pwr_en", pwr_en, 1'b0);
        check("R8 pen_irq_en", pen_irq_en, 1'b1);
        check("R4 oe deselected", {dout_oe, busy_oe}, 2'b00);
    endtask

    // 12-bit, Y position, single-ended, auto power-down
    task automatic t_full_ypos();
        logic [7:0] b;
        b = 8'b1_001_0_1_00;
        select();
        check("R4 oe selected", {dout_oe, busy_oe}, 2'b11);
        conv_data = 12'hA5C;
        for (int i = 7; i >= 0; i--) begin
            tick(b[i]);
            if (tk == 3) check("R7 power during command", pwr_en, 1'b1);
            if (tk == 5) check("R6 drivers before window", drv_y_en, 1'b0);
            if (tk == 6) begin
                check("R6 y driver on", {drv_x_en, drv_y_en}, 2'b01);
                check("R6 mux code", mux_code, 3'b001);
                check("R6 single-ended", ref_ratio, 1'b0);
            end
        end
        tick(1'b0);
        check("R6 drivers off after busy", {drv_x_en, drv_y_en}, 2'b00);
        zeros(15);
        check_result("R3 full", 1, 12'hA5C, 1'b0);
        check("R7 auto power off", pwr_en, 1'b0);
        check("R7 pen enabled", pen_irq_en, 1'b1);
        deselect();
    endtask

    // 8-bit, X position, ratiometric
    task automatic t_short_xpos();
        select();
        conv_data = 12'h3C7;
        send_byte(8'b1_101_1_0_00);
        check("R6 x driver on", {drv_x_en, drv_y_en}, 2'b10);
        check("R6 ratiometric", ref_ratio, 1'b1);
        zeros(12);
        check_result("R3 short", 1, 12'h3C0, 1'b1);
        deselect();
    endtask

    // Leading low bits are not a start bit; aux 3 drives nothing
    task automatic t_lead_zero();
        select();
        conv_data = 12'h6E1;
        zeros(3);
        check("R1 no busy on zeros", busy, 1'b0);
        send_byte(8'b1_010_0_1_00);
        check("R6 aux no drivers", {drv_x_en, drv_y_en}, 2'b00);
        check("R6 aux mux", mux_code, 3'b010);
        zeros(16);
        check_result("R1 framed after zeros", 4, 12'h6E1, 1'b0);
        deselect();
    endtask

    // Partial command then deselect; the partial bits must not frame the next command
    task automatic t_cs_abort();
        select();
        tick(1'b1); tick(1'b1); tick(1'b0); tick(1'b1); tick(1'b1);
        deselect();
        check("R4 busy_oe", busy_oe, 1'b0);
        check("R4 dout_oe", dout_oe, 1'b0);
        check("R4 busy", busy, 1'b0);
        tick(1'b1); tick(1'b1); tick(1'b1);
        check("R4 ignored while deselected", {busy, dout}, 2'b00);
        select();
        conv_data = 12'h123;
        send_byte(8'b1_001_0_1_00);
        zeros(16);
        check_result("R4 fresh command", 1, 12'h123, 1'b0);
        deselect();
    endtask

    // 12-bit result overlapped by an 8-bit, always-powered command on edge 16
    task automatic t_overlap_full();
        bit early_busy;
        select();
        conv_data = 12'h5A3;
        send_byte(8'b1_001_0_1_00);
        conv_data = 12'hC69;
        for (int i = 0; i < 7; i++) tick(1'b1);
        send_byte(8'b1_110_1_1_11);
        zeros(10);
        early_busy = 1'b0;
        for (int k = 9; k <= 21; k++) early_busy |= cap_busy[k];
        check("R5 early start ignored", early_busy, 1'b0);
        check_result("R5 old result", 1, 12'h5A3, 1'b0);
        check_result("R5 new result", 16, 12'hC60, 1'b1);
        check("R6 aux4 mux", mux_code, 3'b110);
        check("R7 held power", pwr_en, 1'b1);
        check("R7 pen disabled", pen_irq_en, 1'b0);
        deselect();
        check("R7 power kept deselected", {pwr_en, pen_irq_en}, 2'b10);
        select();
        conv_data = 12'h0F0;
        send_byte(8'b1_001_0_1_00);
        zeros(16);
        check_result("R7 restore", 1, 12'h0F0, 1'b0);
        check("R7 auto restored", {pwr_en, pen_irq_en}, 2'b01);
        deselect();
    endtask

    // 8-bit result overlapped by a 12-bit command on edge 12
    task automatic t_overlap_short();
        bit early_busy;
        select();
        conv_data = 12'hB4F;
        send_byte(8'b1_101_1_0_00);
        conv_data = 12'h2E7;
        for (int i = 0; i < 3; i++) tick(1'b1);
        send_byte(8'b1_001_0_1_00);
        zeros(16);
        early_busy = 1'b0;
        for (int k = 9; k <= 17; k++) early_busy |= cap_busy[k];
        check("R5 short early start ignored", early_busy, 1'b0);
        check_result("R5 short old result", 1, 12'hB40, 1'b1);
        check_result("R5 short new result", 12, 12'h2E7, 1'b0);
        deselect();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_full_ypos();
        t_short_xpos();
        t_lead_zero();
        t_cs_abort();
        t_overlap_full();
        t_overlap_short();
        done = 1'b1;
        summary();
        $finish;
    end
endmodule